// File: doc/BRIEF.md
# UART Receive FIFO with Character Time-out Interrupt

This block is the receive half of a 16550-style serial channel running in FIFO mode. Characters arrive from an external deserializer as a one-cycle valid strobe with a data byte. They are kept in a 16-entry first-in first-out buffer until the host takes them out, one per read strobe. Reads and writes are accepted in the same cycle when the buffer allows both.

Two interrupt sources are derived from the buffer. The data-ready source asserts when the occupancy reaches a level chosen by a 2-bit selector. The stale-data source asserts when the buffer has held at least one character and nothing went in or came out for four character times. The character-time pulse comes from the baud logic outside the block. Both sources share one enable. The outcome is reported in a registered 8-bit identification byte whose bit 0 is low while an interrupt is pending.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: The buffer holds up to 16 characters and returns them in arrival order. A character offered while the buffer holds 16 is discarded, including when a read happens in the same cycle.
- R2: A read strobe on a non-empty buffer places the oldest character on `rd_data` at the next clock edge. A read strobe on an empty buffer leaves `rd_data` and the buffer unchanged.
- R3: `trig_sel` picks the data-ready level: 0 gives 1 character, 1 gives 4, 2 gives 8 and 3 gives 14. The data-ready condition holds while the occupancy is at or above that level.
- R4: The time-out becomes pending on the fourth `char_tick` pulse that is counted while the buffer holds data. A pulse is not counted in a cycle with an accepted write or read, and any accepted write or read restarts the count from zero. Pulses that arrive while the buffer is empty are not counted.
- R5: Any read strobe clears a pending time-out. An accepted write does not clear it.
- R6: When `rx_irq_en` is low, neither source is reported (`irq_id` reads 0xC1), and a time-out stays pending underneath. Raising the enable again shows it.
- R7: `irq_id` bits 7:6 read 11, bits 5:4 read 00, and bits 3:0 hold the code: 0x4 for data-ready, 0xC for time-out and 0x1 for none. Data-ready wins when both sources are active. The byte is registered and reflects the state after the previous clock edge.
- R8: A `fifo_clr` pulse empties the buffer, zeroes the idle count and clears a pending time-out. A write or read strobe in the same cycle is ignored. `rd_data` is left as it was.
- R9: A synchronous active-high `rst` empties the buffer, clears the time-out and drives `rd_data` to 0x00 and `irq_id` to 0xC1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rd_strobe | input | 1 | Host read of the receive buffer |
| rd_data | output | 8 | Character returned by the last accepted read |
| char_tick | input | 1 | One-cycle pulse per character time |
| fifo_clr | input | 1 | Empties the receive buffer |
| trig_sel | input | 2 | Data-ready level select |
| rx_irq_en | input | 1 | Enable shared by both receive interrupt sources |
| irq_id | output | 8 | Registered identification byte |

## Verification
The embedded assertions check several rules on every cycle. The occupancy bound and the discard of writes when the buffer is full are checked this way. So are the effect of a read on an empty buffer, the clearing effect of a read strobe and of `fifo_clr`, the saturation of the idle count, and that no interrupt is reported while the enable is low. Some behaviour shows only in the bench's scenarios, where a behavioural queue model is compared on every clock. This covers the order in which characters come back, each of the four data-ready levels, and the exact tick on which the time-out fires and how writes restart that count. It also covers data-ready taking priority over the time-out, and a masked time-out reappearing when the enable returns.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  typedef enum logic [3:0] {
    IRQ_CODE_NONE = 4'b0001,
    IRQ_CODE_RDA  = 4'b0100,
    IRQ_CODE_CTO  = 4'b1100
  } irq_code_e;

  localparam logic [1:0] FIFO_ON_BITS = 2'b11;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign push_ok = push_req && !flush && (count != FULL_CNT);
  assign pop_ok  = pop_req  && !flush && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == LAST_IX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R1
  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && push_req && !pop_req && !flush) |=> count == FULL_CNT); // R1
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && pop_req && !push_req) |=> (count == '0 && $stable(dout))); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0); // R8

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TICKS = 4,
  localparam int IW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic activity,
  input  logic has_data,
  input  logic tick,
  input  logic clr,
  output logic pend
);

  localparam logic [IW-1:0] IDLE_MAX = IW'(TICKS);
  localparam logic [IW-1:0] IDLE_PRE = IW'(TICKS - 1);

  logic [IW-1:0] idle;
  logic          count_en;

  assign count_en = !activity && has_data && tick && (idle != IDLE_MAX);

  always_ff @(posedge clk) begin
    if (rst || flush)  idle <= '0;
    else if (activity) idle <= '0;
    else if (count_en) idle <= idle + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush)                          pend <= 1'b0;
    else if (clr)                              pend <= 1'b0;
    else if (count_en && (idle == IDLE_PRE))   pend <= 1'b1;
  end

  AST_IDLE_SAT: assert property (@(posedge clk) disable iff (rst)
    idle <= IDLE_MAX); // R4
  AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(has_data)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pend); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!pend && idle == '0)); // R8

endmodule

// File: rtl/rx_irq_encode.sv
module rx_irq_encode
  import rxto_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  input  logic          cto_pend,
  output logic [7:0]    iid_q
);

  logic      rda;
  irq_code_e code;

  assign rda = (32'(count) >= trig_level(sel));

  always_comb begin
    if (en && rda)           code = IRQ_CODE_RDA;
    else if (en && cto_pend) code = IRQ_CODE_CTO;
    else                     code = IRQ_CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) iid_q <= {FIFO_ON_BITS, 2'b00, IRQ_CODE_NONE};
    else     iid_q <= {FIFO_ON_BITS, 2'b00, code};
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> iid_q[0]); // R6
  AST_FIFO_ONLY_BIT: assert property (@(posedge clk) disable iff (rst)
    iid_q[3] |-> (iid_q[3:0] == 4'hC)); // R7
  AST_RDA_FIRST: assert property (@(posedge clk) disable iff (rst)
    (en && rda) |=> (iid_q[3:0] == 4'h4)); // R7

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_TICKS = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rd_strobe,
  output logic [DW-1:0] rd_data,
  input  logic          char_tick,
  input  logic          fifo_clr,
  input  logic [1:0]    trig_sel,
  input  logic          rx_irq_en,
  output logic [7:0]    irq_id
);

  logic [CW-1:0] occ;
  logic          wr_ok, rd_ok, cto_pend;

  rx_char_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_clr),
    .push_req(rx_valid), .din(rx_data),
    .pop_req(rd_strobe), .dout(rd_data),
    .count(occ), .push_ok(wr_ok), .pop_ok(rd_ok)
  );

  rx_idle_timer #(.TICKS(TO_TICKS)) u_timer (
    .clk(clk), .rst(rst), .flush(fifo_clr),
    .activity(wr_ok || rd_ok), .has_data(occ != '0),
    .tick(char_tick), .clr(rd_strobe), .pend(cto_pend)
  );

  rx_irq_encode #(.CW(CW)) u_enc (
    .clk(clk), .rst(rst), .en(rx_irq_en), .sel(trig_sel),
    .count(occ), .cto_pend(cto_pend), .iid_q(irq_id)
  );

endmodule

// File: tb/uart_rx_fifo_irq_tb_top.sv
module uart_rx_fifo_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rd_strobe = 1'b0;
  logic       char_tick = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       rx_irq_en = 1'b0;
  logic [7:0] rd_data, irq_id;

  always #4 clk = ~clk;

  uart_rx_fifo_irq dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .char_tick(char_tick),
    .fifo_clr(fifo_clr), .trig_sel(trig_sel), .rx_irq_en(rx_irq_en),
    .irq_id(irq_id)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R9";

  logic [7:0] q[$];
  int         m_idle = 0;
  bit         m_pend = 0;
  logic [7:0] m_iid = 8'hC1;
  logic [7:0] m_rd = 8'h00;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: lvl = 1;
      2'd1: lvl = 4;
      2'd2: lvl = 8;
      default: lvl = 14;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    bit push, pop, rda;
    rda = rx_irq_en && (q.size() >= lvl(trig_sel));
    if (rda)                    m_iid = 8'hC4;
    else if (rx_irq_en && m_pend) m_iid = 8'hCC;
    else                        m_iid = 8'hC1;
    if (rst) begin
      q.delete(); m_idle = 0; m_pend = 0; m_iid = 8'hC1; m_rd = 8'h00;
    end else if (fifo_clr) begin
      q.delete(); m_idle = 0; m_pend = 0;
    end else begin
      push = rx_valid && (q.size() < 16);
      pop  = rd_strobe && (q.size() > 0);
      if (pop) m_rd = q.pop_front();
      if (push) q.push_back(rx_data);
      if (rd_strobe) m_pend = 0;
      if (push || pop) m_idle = 0;
      else if (q.size() > 0 && char_tick && m_idle < 4) begin
        m_idle++;
        if (m_idle == 4) m_pend = 1;
      end
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit r, input bit t, input bit fc);
    rx_valid = v; rx_data = d; rd_strobe = r; char_tick = t; fifo_clr = fc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rx_valid = 0; rd_strobe = 0; char_tick = 0; fifo_clr = 0;
    chk({cur_req, " iid"}, irq_id, m_iid);
    chk({cur_req, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic idle1();                     step(0, 8'h00, 0, 0, 0); endtask
  task automatic push1(input logic [7:0] d);  step(1, d, 0, 0, 0);     endtask
  task automatic read1();                     step(0, 8'h00, 1, 0, 0); endtask
  task automatic tick1();                     step(0, 8'h00, 0, 1, 0); endtask
  task automatic clr1();                      step(0, 8'h00, 0, 0, 1); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    model_edge();
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset iid", irq_id, 8'hC1);
    chk("R9 reset rd_data", rd_data, 8'h00);

    // R1: fill past capacity with interrupts masked; R6 masks data-ready
    cur_req = "R1"; rx_irq_en = 0; trig_sel = 2'd0;
    for (int i = 0; i < 18; i++) push1(8'h10 + 8'(i));
    idle1();
    chk("R6 masked full", irq_id, 8'hC1);
    // R1 simultaneous push and read while full: the push is dropped
    step(1, 8'hEE, 1, 0, 0);
    chk("R1 read while full", rd_data, 8'h10);
    // R2 drain in order
    cur_req = "R2";
    for (int i = 0; i < 15; i++) read1();
    chk("R2 last char", rd_data, 8'h1F);
    read1();
    chk("R2 empty read keeps data", rd_data, 8'h1F);

    // R3: each data-ready level
    cur_req = "R3"; rx_irq_en = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      clr1();
      for (int i = 0; i < lvl(2'(s)) - 1; i++) push1(8'h40 + 8'(i));
      idle1();
      chk("R3 below level", irq_id, 8'hC1);
      push1(8'h7F);
      idle1();
      chk("R3 at level", irq_id, 8'hC4);
    end

    // R4: time-out after four counted ticks
    cur_req = "R4"; trig_sel = 2'd3;
    clr1();
    for (int i = 0; i < 5; i++) tick1();
    push1(8'hA1);
    for (int i = 0; i < 3; i++) tick1();
    idle1();
    chk("R4 three ticks", irq_id, 8'hC1);
    tick1(); idle1();
    chk("R4 fourth tick", irq_id, 8'hCC);
    // R4 restart on write; R5 write does not clear pending
    clr1();
    push1(8'hA2);
    for (int i = 0; i < 3; i++) tick1();
    step(1, 8'hA3, 0, 1, 0);
    for (int i = 0; i < 3; i++) tick1();
    idle1();
    chk("R4 restarted by write", irq_id, 8'hC1);
    tick1(); idle1();
    chk("R4 fires after restart", irq_id, 8'hCC);
    cur_req = "R5";
    push1(8'hA4); idle1();
    chk("R5 write keeps pending", irq_id, 8'hCC);
    read1(); idle1();
    chk("R5 read clears", irq_id, 8'hC1);
    chk("R5 read data", rd_data, 8'hA2);

    // R6: masked time-out stays pending underneath
    cur_req = "R6";
    rx_irq_en = 0;
    for (int i = 0; i < 4; i++) tick1();
    idle1();
    chk("R6 masked timeout", irq_id, 8'hC1);
    rx_irq_en = 1;
    idle1(); idle1();
    chk("R6 unmasked timeout", irq_id, 8'hCC);

    // R7: data-ready wins over time-out
    cur_req = "R7";
    trig_sel = 2'd0;
    idle1(); idle1();
    chk("R7 priority", irq_id, 8'hC4);
    trig_sel = 2'd3;
    idle1(); idle1();
    chk("R7 timeout code", irq_id, 8'hCC);

    // R8: FIFO clear drops data and pending time-out
    cur_req = "R8";
    step(1, 8'h55, 1, 0, 1);
    idle1();
    chk("R8 cleared iid", irq_id, 8'hC1);
    chk("R8 rd_data kept", rd_data, 8'hA2);
    trig_sel = 2'd0;
    read1(); idle1();
    chk("R8 empty after clear", irq_id, 8'hC1);
    chk("R8 no data after clear", rd_data, 8'hA2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule